// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small processor built around one accumulator. A program counter addresses a single synchronous memory port to bring in a 16-bit instruction word, which is held in an instruction register. The core then decodes that word and carries it out. It can load the accumulator from memory, combine a memory operand with the accumulator through an adder or AND/OR logic, write the accumulator back to memory, or transfer control to a new address. A zero flag follows every value written into the accumulator.

A single address multiplexer drives the memory address. It picks the program counter while an instruction is being fetched and the instruction register's address field while data is being accessed. The ALU reaches subtraction by inverting its second operand and forcing a carry into the adder. Each instruction runs as a fixed sequence of steps: fetch, decode, execute and, for instructions that read a memory operand, one more step to absorb the memory's read latency.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, the program counter, instruction register, accumulator and zero flag are all zero, `mem_addr` is 0 and `mem_we` is low.
- R2: An instruction word is `{opcode[15:12], field[11:0]}` with opcodes 0=no-op, 1=load, 2=add, 3=subtract, 4=and, 5=or, 6=store, 7=jump. Each instruction reads memory at the program counter, and the program counter then advances by one. Decode follows, then execute. Opcodes 1 to 5 take one further cycle.
- R3: Load (1) places the memory word at `field` into the accumulator.
- R4: Add (2) sets the accumulator to accumulator plus the memory word at `field`, modulo 2^16.
- R5: Subtract (3) sets the accumulator to accumulator minus the memory word at `field`, modulo 2^16. It is formed on the adder with the operand inverted and a carry-in of one.
- R6: And (4) and Or (5) combine the accumulator bitwise with the memory word at `field`.
- R7: Store (6) writes the accumulator to memory at `field`, with `mem_we` high for exactly one cycle and `mem_wdata` equal to the accumulator.
- R8: Jump (7) makes the next instruction fetch read from address `field`. The instructions after the jump are not executed.
- R9: `zero` is 1 exactly when the last value written into the accumulator was 0. Store, jump and no-op leave both the flag and the accumulator unchanged.
- R10: Opcode 0 and opcodes 8 to 15 change neither the accumulator nor the flag, write nothing, and let execution continue at the next address.
- R11: `mem_addr` equals the program counter during instruction fetch and the instruction's `field` during data reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W (12) | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W (16) | Data to write (the accumulator) |
| mem_rdata | input | DATA_W (16) | Read data, valid one cycle after its address |
| acc | output | DATA_W (16) | Accumulator value |
| zero | output | 1 | Zero flag |

## Verification
The properties assume that the memory returns the word at an address on the cycle after that address is presented, that a write lands at the clock edge that ends the store cycle, and that `mem_rdata` is never unknown once reset is released. The bench's memory model is a 256-word array that registers its read data on every edge and performs the write on that same edge. The program uses only addresses inside that array and fills every location before reset is released, so each fetch and operand read returns a defined word. The stimulus keeps reset high for several cycles before running the program, and asserts it again only after the program has settled into its final self-jump.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
    localparam logic [OP_W-1:0] OP_ADD   = 4'd2;
    localparam logic [OP_W-1:0] OP_SUB   = 4'd3;
    localparam logic [OP_W-1:0] OP_AND   = 4'd4;
    localparam logic [OP_W-1:0] OP_OR    = 4'd5;
    localparam logic [OP_W-1:0] OP_STORE = 4'd6;
    localparam logic [OP_W-1:0] OP_JMP   = 4'd7;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_MEMRD  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_ADD  = 2'd1,
        FN_AND  = 2'd2,
        FN_OR   = 2'd3
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    b_inv;
        logic    carry_in;
    } alu_ctl_t;

    typedef struct packed {
        logic     pc_inc;
        logic     pc_load;
        logic     ir_load;
        logic     addr_from_ir;
        logic     mem_we;
        logic     acc_load;
        alu_ctl_t alu;
    } ctl_t;

    function automatic logic reads_operand(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
               (op == OP_AND)  || (op == OP_OR);
    endfunction

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;

    always_comb begin
        b_eff = ctl.b_inv ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, ctl.carry_in};
        unique case (ctl.fn)
            FN_PASS: y = b;
            FN_ADD:  y = sum;
            FN_AND:  y = a & b_eff;
            FN_OR:   y = a | b_eff;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/cpu_addr_mux.sv
module cpu_addr_mux #(
    parameter int AW = 12
) (
    input  logic          use_ir,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] ir_field,
    output logic [AW-1:0] addr
);
    assign addr = use_ir ? ir_field : pc;
endmodule

// File: rtl/cpu_seq.sv
module cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output phase_e          phase,
    output ctl_t            ctl
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
        end else begin
            unique case (phase_q)
                PH_FETCH:  phase_q <= PH_DECODE;
                PH_DECODE: phase_q <= PH_EXEC;
                PH_EXEC:   phase_q <= reads_operand(opcode) ? PH_MEMRD : PH_FETCH;
                PH_MEMRD:  phase_q <= PH_FETCH;
                default:   phase_q <= PH_FETCH;
            endcase
        end
    end

    always_comb begin
        ctl = '0;
        unique case (phase_q)
            PH_FETCH:  ctl.pc_inc  = 1'b1;
            PH_DECODE: ctl.ir_load = 1'b1;
            PH_EXEC: begin
                ctl.addr_from_ir = 1'b1;
                ctl.mem_we       = (opcode == OP_STORE);
                ctl.pc_load      = (opcode == OP_JMP);
            end
            PH_MEMRD: begin
                ctl.addr_from_ir = 1'b1;
                ctl.acc_load     = 1'b1;
                case (opcode)
                    OP_ADD:  ctl.alu.fn = FN_ADD;
                    OP_SUB: begin
                        ctl.alu.fn       = FN_ADD;
                        ctl.alu.b_inv    = 1'b1;
                        ctl.alu.carry_in = 1'b1;
                    end
                    OP_AND:  ctl.alu.fn = FN_AND;
                    OP_OR:   ctl.alu.fn = FN_OR;
                    default: ctl.alu.fn = FN_PASS;
                endcase
            end
            default: ctl = '0;
        endcase
    end

    assign phase = phase_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc,
    output logic              zero
);
    localparam int OPC_LSB = DATA_W - OP_W;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic              zero_q;
    logic [DATA_W-1:0] alu_y;
    logic [ADDR_W-1:0] ir_field;
    logic [OP_W-1:0]   opcode;
    phase_e            phase;
    ctl_t              ctl;

    assign opcode   = ir_q[DATA_W-1:OPC_LSB];
    assign ir_field = ir_q[ADDR_W-1:0];

    cpu_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .phase  (phase),
        .ctl    (ctl)
    );

    cpu_addr_mux #(.AW(ADDR_W)) u_amux (
        .use_ir   (ctl.addr_from_ir),
        .pc       (pc_q),
        .ir_field (ir_field),
        .addr     (mem_addr)
    );

    cpu_alu #(.W(DATA_W)) u_alu (
        .a   (acc_q),
        .b   (mem_rdata),
        .ctl (ctl.alu),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ir_q   <= '0;
            acc_q  <= '0;
            zero_q <= 1'b0;
        end else begin
            if (ctl.pc_load) begin
                pc_q <= ir_field;
            end else if (ctl.pc_inc) begin
                pc_q <= pc_q + ADDR_W'(1);
            end
            if (ctl.ir_load) begin
                ir_q <= mem_rdata;
            end
            if (ctl.acc_load) begin
                acc_q  <= alu_y;
                zero_q <= (alu_y == '0);
            end
        end
    end

    assign mem_we    = ctl.mem_we;
    assign mem_wdata = acc_q;
    assign acc       = acc_q;
    assign zero      = zero_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] acc,
    input logic              zero,
    input logic [ADDR_W-1:0] pc,
    input phase_e            phase
);
    AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == '0 && !mem_we && acc == '0 && !zero)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (pc == $past(pc) + ADDR_W'(1))); // R2

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R7

    AST_WE_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_EXEC)); // R7

    AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc) |-> (zero == (acc == '0))); // R9

    AST_STORE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> ($stable(acc) && $stable(zero))); // R9

    AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_addr == pc)); // R11
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .acc      (acc),
    .zero     (zero),
    .pc       (pc_q),
    .phase    (phase)
);

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [15:0] acc;
    logic        zero;

    int  nvec = 0;
    int  nbad = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        logic [11:0] a;
        logic [15:0] d;
        logic        z;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [15:0] mem [256];

    always #2 clk = ~clk;

    acc_cpu u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .acc       (acc),
        .zero      (zero)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [3:0] op, input logic [11:0] f);
        mem[a] = {op, f};
    endtask

    task automatic expect_store(input logic [11:0] a, input logic [15:0] d,
                                input logic z, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.z = z; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: every write strobe is compared to the next expected store
    always @(negedge clk) begin
        if (mon_en && !rst && mem_we) begin
            if (q.size() == 0) begin
                nvec++; nbad++;
                $display("FAIL R8: actual unexpected store %h@%h expected none", mem_wdata, mem_addr);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " store address"}, 32'(mem_addr), 32'(e.a));
                chk({e.tag, " store data"}, 32'(mem_wdata), 32'(e.d));
                chk({e.tag, " zero flag"}, 32'(zero), 32'(e.z));
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        // operands
        mem[8'h80] = 16'h1234; mem[8'h81] = 16'h0F0F; mem[8'h82] = 16'h2143;
        mem[8'h83] = 16'h0001; mem[8'h84] = 16'h00F0; mem[8'h85] = 16'h0F00;
        mem[8'h86] = 16'hF010; mem[8'h87] = 16'h5555; mem[8'h88] = 16'h8000;
        mem[8'h89] = 16'h0000;
        // program
        put(8'h00, 4'd1, 12'h080);  expect_store(12'h0A0, 16'h1234, 1'b0, "R3");
        put(8'h01, 4'd6, 12'h0A0);
        put(8'h02, 4'd2, 12'h081);  expect_store(12'h0A1, 16'h2143, 1'b0, "R4");
        put(8'h03, 4'd6, 12'h0A1);
        put(8'h04, 4'd3, 12'h082);  expect_store(12'h0A2, 16'h0000, 1'b1, "R5");
        put(8'h05, 4'd6, 12'h0A2);
        put(8'h06, 4'd3, 12'h083);  expect_store(12'h0A3, 16'hFFFF, 1'b0, "R5");
        put(8'h07, 4'd6, 12'h0A3);
        put(8'h08, 4'd4, 12'h084);
        put(8'h09, 4'd5, 12'h085);  expect_store(12'h0A4, 16'h0FF0, 1'b0, "R6");
        put(8'h0A, 4'd6, 12'h0A4);
        put(8'h0B, 4'd2, 12'h086);  expect_store(12'h0A5, 16'h0000, 1'b1, "R4");
        put(8'h0C, 4'd6, 12'h0A5);
        put(8'h0D, 4'd0, 12'h0A6);
        put(8'h0E, 4'd15, 12'h0A6); expect_store(12'h0A6, 16'h0000, 1'b1, "R10");
        put(8'h0F, 4'd6, 12'h0A6);
        put(8'h10, 4'd7, 12'h020);
        put(8'h11, 4'd1, 12'h087);
        put(8'h12, 4'd6, 12'h0A7);
        put(8'h20, 4'd1, 12'h088);  expect_store(12'h0A8, 16'h8000, 1'b0, "R8");
        put(8'h21, 4'd6, 12'h0A8);  expect_store(12'h0A9, 16'h8000, 1'b0, "R9");
        put(8'h22, 4'd6, 12'h0A9);
        put(8'h23, 4'd1, 12'h089);  expect_store(12'h0AA, 16'h0000, 1'b1, "R11");
        put(8'h24, 4'd6, 12'h0AA);
        put(8'h25, 4'd1, 12'h080);
        put(8'h26, 4'd7, 12'h026);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset address", 32'(mem_addr), 32'h0);
        chk("R1 reset write strobe", 32'(mem_we), 32'h0);
        chk("R1 reset accumulator", 32'(acc), 32'h0);
        chk("R1 reset zero flag", 32'(zero), 32'h0);
        rst = 1'b0;
        mon_en = 1'b1;

        repeat (300) @(negedge clk);
        chk("R8 all expected stores seen", 32'(q.size()), 32'h0);
        chk("R8 skipped store absent", 32'(mem[8'hA7]), 32'h0);
        chk("R7 memory holds stored word", 32'(mem[8'hA4]), 32'h0FF0);
        chk("R3 final accumulator", 32'(acc), 32'h1234);
        chk("R9 final zero flag", 32'(zero), 32'h0);
        chk("R2 self-jump holds fetch in range", 32'(mem_addr <= 12'h026), 32'h1);

        mon_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 re-reset accumulator", 32'(acc), 32'h0);
        chk("R1 re-reset zero flag", 32'(zero), 32'h0);
        chk("R1 re-reset address", 32'(mem_addr), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            nvec++; nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule